// File: doc/BRIEF.md
# Packed Pixel Arithmetic Unit

This block runs lane-parallel arithmetic on 32-bit words that carry packed pixel data. The same word is treated either as four unsigned 8-bit lanes or as two signed 16-bit lanes. One operation is issued per cycle, selected by a 3-bit code. It can be a clipped add, a rounding byte average, a byte window taken from the two sources side by side, or a sum-of-absolute-differences step. The sum-of-absolute-differences step feeds four 16-bit saturating accumulators, one per byte lane.

Every operation takes one cycle. The packed result and a valid flag appear after the clock edge that captured the request, and the accumulators update on that same edge. Motion-estimation code clears the accumulators, streams block rows through the difference operation, and then reads the four lane totals.

Top module: `pixel_simd_unit`

## Requirements
- R1: After reset, `result` is 0, `result_valid` is 0 and all four accumulators are 0.
- R2: Operation code 0 adds each unsigned byte lane (bits [8i+7:8i]) of `src_a` and `src_b` and clamps the result to 255. The result appears on the edge after the request is presented.
- R3: Operation code 1 adds the two signed 16-bit halves separately and saturates each half to the range -32768..32767.
- R4: Operation code 2 gives (a+b+1)>>1 for each byte lane, so an odd sum rounds up. No carry passes from one lane to the next.
- R5: Operation code 3 writes |a_i-b_i| into byte lane i of `result`. It also adds that value to accumulator i, which is `acc_out[16i+15:16i]`.
- R6: An accumulator whose new total would pass 0xFFFF stays at 0xFFFF.
- R7: `acc_clr` sets all accumulators to 0. It acts whether or not `op_valid` is high. If it arrives together with an operation code 3 request, each accumulator is loaded with just that request's difference.
- R8: Operation code 4 outputs bits [8k+31:8k] of the 64-bit concatenation {`src_b`,`src_a`}, where k is `align_off` (0..3).
- R9: `result_valid` equals `op_valid` from the previous cycle. While `op_valid` is low, `result` holds its value. Codes 5 to 7 with `op_valid` high give a `result` of 0.
- R10: The accumulators change only on an operation code 3 request or on `acc_clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request present this cycle |
| op_sel | input | 3 | Operation code (0 add8, 1 add16, 2 avg8, 3 abs-diff accumulate, 4 byte window) |
| align_off | input | 2 | Byte offset for the window operation |
| src_a | input | 32 | First packed source, low half of the window |
| src_b | input | 32 | Second packed source, high half of the window |
| acc_clr | input | 1 | Clear the four accumulators |
| result | output | 32 | Registered packed result |
| result_valid | output | 1 | Result produced by a request on the previous cycle |
| acc_out | output | 64 | Four 16-bit accumulators, lane i at bits [16i+15:16i] |

## Verification
The byte add and the average are swept over a grid of operand pairs that spans 0..255 in every lane. Each lane gets a different mix, so clamping, round-up on odd sums and carry leakage between lanes each show up as a distinct mismatch. The 16-bit add is swept from the negative limit to the positive limit, which covers overflow in both directions and sums that must not saturate. The accumulate path first runs a pseudo-random stream against a running model, then a run of maximal differences that drives every lane into saturation. After that it tests clear on its own and clear together with an accumulate. Every window offset is tried on patterns whose bytes are all distinct, so any offset error appears as a shifted byte.

// File: rtl/pixel_simd_pkg.sv
package pixel_simd_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD8  = 3'd0,
        OP_ADD16 = 3'd1,
        OP_AVG8  = 3'd2,
        OP_SAD   = 3'd3,
        OP_WIN   = 3'd4
    } pix_op_e;

endpackage

// File: rtl/psu_lane_add.sv
// Lane-wise add with per-lane clamping; SIGNED_SAT picks the variant.
module psu_lane_add #(
    parameter int W          = 8,
    parameter int N          = 4,
    parameter bit SIGNED_SAT = 1'b0
) (
    input  logic [N*W-1:0] a,
    input  logic [N*W-1:0] b,
    output logic [N*W-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] la, lb;
        assign la = a[i*W +: W];
        assign lb = b[i*W +: W];
        if (SIGNED_SAT) begin : g_sgn
            logic [W-1:0] s;
            logic         ovf;
            assign s   = la + lb;
            assign ovf = (la[W-1] == lb[W-1]) && (s[W-1] != la[W-1]);
            assign y[i*W +: W] = ovf ? (la[W-1] ? {1'b1, {(W-1){1'b0}}}
                                                : {1'b0, {(W-1){1'b1}}})
                                     : s;
        end else begin : g_uns
            logic [W:0] s;
            assign s = {1'b0, la} + {1'b0, lb};
            assign y[i*W +: W] = s[W] ? {W{1'b1}} : s[W-1:0];
        end
    end
endmodule

// File: rtl/psu_lane_avg.sv
// Per-lane rounding average; carry bit kept inside the lane.
module psu_lane_avg #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N*W-1:0] a,
    input  logic [N*W-1:0] b,
    output logic [N*W-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W:0] s;
        assign s = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]} + {{W{1'b0}}, 1'b1};
        assign y[i*W +: W] = s[W:1];
    end
endmodule

// File: rtl/psu_lane_absdiff.sv
// Per-lane absolute difference of unsigned lanes.
module psu_lane_absdiff #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N*W-1:0] a,
    input  logic [N*W-1:0] b,
    output logic [N*W-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [W-1:0] la, lb;
        assign la = a[i*W +: W];
        assign lb = b[i*W +: W];
        assign y[i*W +: W] = (la >= lb) ? (la - lb) : (lb - la);
    end
endmodule

// File: rtl/psu_byte_window.sv
// Picks N consecutive lanes out of the 2N-lane concatenation {b,a}.
module psu_byte_window #(
    parameter int W     = 8,
    parameter int N     = 4,
    parameter int OFF_W = 2
) (
    input  logic [N*W-1:0]   a,
    input  logic [N*W-1:0]   b,
    input  logic [OFF_W-1:0] off,
    output logic [N*W-1:0]   y
);
    logic [2*N*W-1:0] wide;
    assign wide = {b, a};
    assign y    = wide[int'(off)*W +: N*W];
endmodule

// File: rtl/psu_sad_accum.sv
// Next-value logic for the saturating per-lane accumulators.
module psu_sad_accum #(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int N  = 4
) (
    input  logic [N*DW-1:0] diff,
    input  logic [N*AW-1:0] acc_q,
    input  logic            clr,
    input  logic            en,
    output logic [N*AW-1:0] acc_d
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [AW-1:0] base;
        logic [AW:0]   sum;
        assign base = clr ? '0 : acc_q[i*AW +: AW];
        assign sum  = {1'b0, base} + {{(AW+1-DW){1'b0}}, diff[i*DW +: DW]};
        assign acc_d[i*AW +: AW] = !en    ? base :
                                   sum[AW] ? {AW{1'b1}} : sum[AW-1:0];
    end
endmodule

// File: rtl/pixel_simd_unit.sv
module pixel_simd_unit
    import pixel_simd_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int ACC_W  = 16,
    parameter int OFF_W  = $clog2(LANES),
    parameter int WORD_W = LANES * LANE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [OP_W-1:0]        op_sel,
    input  logic [OFF_W-1:0]       align_off,
    input  logic [WORD_W-1:0]      src_a,
    input  logic [WORD_W-1:0]      src_b,
    input  logic                   acc_clr,
    output logic [WORD_W-1:0]      result,
    output logic                   result_valid,
    output logic [LANES*ACC_W-1:0] acc_out
);
    localparam int HALF_LANES = LANES / 2;
    localparam int HALF_W     = 2 * LANE_W;
    localparam int ACC_TOT_W  = LANES * ACC_W;

    typedef struct packed {
        logic [WORD_W-1:0]    result;
        logic                 valid;
        logic [ACC_TOT_W-1:0] acc;
    } state_t;

    state_t  st_q, st_d;
    pix_op_e op;

    logic [WORD_W-1:0]    add8_y, add16_y, avg_y, sad_y, win_y;
    logic [ACC_TOT_W-1:0] acc_next;
    logic                 sad_en;

    assign op     = pix_op_e'(op_sel);
    assign sad_en = op_valid && (op == OP_SAD);

    psu_lane_add #(.W(LANE_W), .N(LANES), .SIGNED_SAT(1'b0)) u_add8 (
        .a(src_a), .b(src_b), .y(add8_y)
    );

    psu_lane_add #(.W(HALF_W), .N(HALF_LANES), .SIGNED_SAT(1'b1)) u_add16 (
        .a(src_a), .b(src_b), .y(add16_y)
    );

    psu_lane_avg #(.W(LANE_W), .N(LANES)) u_avg (
        .a(src_a), .b(src_b), .y(avg_y)
    );

    psu_lane_absdiff #(.W(LANE_W), .N(LANES)) u_absd (
        .a(src_a), .b(src_b), .y(sad_y)
    );

    psu_byte_window #(.W(LANE_W), .N(LANES), .OFF_W(OFF_W)) u_win (
        .a(src_a), .b(src_b), .off(align_off), .y(win_y)
    );

    psu_sad_accum #(.DW(LANE_W), .AW(ACC_W), .N(LANES)) u_acc (
        .diff(sad_y), .acc_q(st_q.acc), .clr(acc_clr), .en(sad_en), .acc_d(acc_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        st_d.acc   = acc_next;
        if (op_valid) begin
            case (op)
                OP_ADD8:  st_d.result = add8_y;
                OP_ADD16: st_d.result = add16_y;
                OP_AVG8:  st_d.result = avg_y;
                OP_SAD:   st_d.result = sad_y;
                OP_WIN:   st_d.result = win_y;
                default:  st_d.result = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result       = st_q.result;
    assign result_valid = st_q.valid;
    assign acc_out      = st_q.acc;

endmodule

// File: rtl/pixel_simd_unit_chk.sv
module pixel_simd_unit_chk
    import pixel_simd_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int ACC_W  = 16,
    parameter int OFF_W  = $clog2(LANES),
    parameter int WORD_W = LANES * LANE_W
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_valid,
    input logic [OP_W-1:0]        op_sel,
    input logic [OFF_W-1:0]       align_off,
    input logic [WORD_W-1:0]      src_a,
    input logic [WORD_W-1:0]      src_b,
    input logic                   acc_clr,
    input logic [WORD_W-1:0]      result,
    input logic                   result_valid,
    input logic [LANES*ACC_W-1:0] acc_out
);
    logic is_sad;
    assign is_sad = op_valid && (op_sel == OP_SAD);

    assert_valid_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> result_valid == $past(op_valid));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

    assert_acc_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !is_sad) |=> $stable(acc_out));

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && !is_sad) |=> acc_out == '0);

    assert_window_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_WIN && align_off == '0) |=> result == $past(src_a));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assert_acc_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sad && !acc_clr) |=>
                acc_out[i*ACC_W +: ACC_W] >= $past(acc_out[i*ACC_W +: ACC_W]));

        assert_avg_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_sel == OP_AVG8) |=>
                ((result[i*LANE_W +: LANE_W] >= $past(src_a[i*LANE_W +: LANE_W])) ||
                 (result[i*LANE_W +: LANE_W] >= $past(src_b[i*LANE_W +: LANE_W]))) &&
                ((result[i*LANE_W +: LANE_W] <= $past(src_a[i*LANE_W +: LANE_W])) ||
                 (result[i*LANE_W +: LANE_W] <= $past(src_b[i*LANE_W +: LANE_W]))));
    end
endmodule

bind pixel_simd_unit pixel_simd_unit_chk #(
    .LANE_W(LANE_W), .LANES(LANES), .ACC_W(ACC_W), .OFF_W(OFF_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .align_off(align_off), .src_a(src_a), .src_b(src_b), .acc_clr(acc_clr),
    .result(result), .result_valid(result_valid), .acc_out(acc_out)
);

// File: tb/pixel_simd_unit_bench.sv
module pixel_simd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [1:0]  align_off = 2'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        acc_clr = 1'b0;
    logic [31:0] result;
    logic        result_valid;
    logic [63:0] acc_out;

    int n_chk  = 0;
    int n_fail = 0;
    int macc[4];
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    pixel_simd_unit u_pixel_simd_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .align_off(align_off), .src_a(src_a), .src_b(src_b), .acc_clr(acc_clr),
        .result(result), .result_valid(result_valid), .acc_out(acc_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_add8(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]);
            if (s > 255) s = 255;
            r[8*i +: 8] = s[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_add16(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int h = 0; h < 2; h++) begin
            int s;
            s = int'($signed(a[16*h +: 16])) + int'($signed(b[16*h +: 16]));
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            r[16*h +: 16] = s[15:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_avg(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = (int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + 1) / 2;
            r[8*i +: 8] = s[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] m_absd(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            int s;
            s = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
            if (s < 0) s = -s;
            r[8*i +: 8] = s[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] m_acc_vec();
        logic [63:0] v;
        for (int i = 0; i < 4; i++) v[16*i +: 16] = macc[i][15:0];
        return v;
    endfunction

    task automatic model_sad(input logic [31:0] a, input logic [31:0] b, input logic clr);
        logic [31:0] d;
        d = m_absd(a, b);
        for (int i = 0; i < 4; i++) begin
            if (clr) macc[i] = 0;
            macc[i] = macc[i] + int'(d[8*i +: 8]);
            if (macc[i] > 65535) macc[i] = 65535;
        end
    endtask

    // Present one request at the falling edge; sample 2 ns after the capturing edge.
    task automatic issue(input logic v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] off, input logic clr);
        @(negedge clk);
        op_valid = v; op_sel = op; src_a = a; src_b = b; align_off = off; acc_clr = clr;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] v16(input int i);
        int t;
        t = (i == 63) ? 32767 : (-32768 + i * 1040);
        return t[15:0];
    endfunction

    task automatic run_all();
        logic [31:0] a, b, keep;
        logic [63:0] acc_keep;

        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1 result", {32'd0, result}, 64'd0);
        check("R1 valid", {63'd0, result_valid}, 64'd0);
        check("R1 acc", acc_out, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 unsigned byte add with clamp
        for (int x = 0; x < 256; x += 5) begin
            for (int y = 0; y < 256; y += 7) begin
                a = {x[7:0], 8'(255 - x), y[7:0], x[7:0]};
                b = {y[7:0], x[7:0], 8'(255 - y), y[7:0]};
                issue(1'b1, 3'd0, a, b, 2'd0, 1'b0);
                check("R2 add8", {32'd0, result}, {32'd0, m_add8(a, b)});
            end
        end
        check("R9 valid after request", {63'd0, result_valid}, 64'd1);
        check("R10 acc untouched by add8", acc_out, 64'd0);

        // R3 signed halfword add with saturation
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                a = {v16(i), v16(63 - i)};
                b = {v16(j), v16(j)};
                issue(1'b1, 3'd1, a, b, 2'd0, 1'b0);
                check("R3 add16", {32'd0, result}, {32'd0, m_add16(a, b)});
            end
        end

        // R4 rounding average, no lane carry
        for (int x = 0; x < 256; x += 5) begin
            for (int y = 0; y < 256; y += 7) begin
                a = {x[7:0], 8'(255 - x), y[7:0], 8'(x ^ y)};
                b = {y[7:0], x[7:0], 8'(255 - y), 8'(x + 1)};
                issue(1'b1, 3'd2, a, b, 2'd0, 1'b0);
                check("R4 avg8", {32'd0, result}, {32'd0, m_avg(a, b)});
            end
        end
        issue(1'b1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, 1'b0);
        check("R4 avg8 all ones", {32'd0, result}, 64'h0000_0000_FFFF_FFFF);
        issue(1'b1, 3'd2, 32'h0101_0101, 32'h0000_0000, 2'd0, 1'b0);
        check("R4 avg8 round up", {32'd0, result}, 64'h0000_0000_0101_0101);

        // R8 byte window at every offset
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] w;
                a = 32'h0302_0100 + 32'h1010_1010 * p;
                b = 32'h0706_0504 + 32'h1010_1010 * p;
                w = {b, a} >> (8 * k);
                issue(1'b1, 3'd4, a, b, k[1:0], 1'b0);
                check("R8 window", {32'd0, result}, {32'd0, w[31:0]});
            end
        end

        // R9 unused codes give zero
        for (int c = 5; c < 8; c++) begin
            issue(1'b1, c[2:0], 32'hDEAD_BEEF, 32'h1234_5678, 2'd1, 1'b0);
            check("R9 unused code result", {32'd0, result}, 64'd0);
            check("R10 unused code acc", acc_out, 64'd0);
        end

        // R5 accumulate against a running model
        for (int i = 0; i < 4; i++) macc[i] = 0;
        for (int n = 0; n < 300; n++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            a = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            b = rng;
            issue(1'b1, 3'd3, a, b, 2'd0, 1'b0);
            model_sad(a, b, 1'b0);
            check("R5 sad result", {32'd0, result}, {32'd0, m_absd(a, b)});
            check("R5 sad acc", acc_out, m_acc_vec());
        end

        // R9 / R10 idle hold
        keep = result;
        acc_keep = acc_out;
        issue(1'b0, 3'd3, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0);
        check("R9 idle result hold", {32'd0, result}, {32'd0, keep});
        check("R9 idle valid low", {63'd0, result_valid}, 64'd0);
        check("R10 idle acc hold", acc_out, acc_keep);

        // R6 saturation
        for (int n = 0; n < 260; n++) begin
            issue(1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0000_0000, 2'd0, 1'b0);
            model_sad(32'hFFFF_FFFF, 32'h0, 1'b0);
        end
        check("R6 saturate", acc_out, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R6 model agrees", acc_out, m_acc_vec());
        issue(1'b1, 3'd3, 32'h0000_0000, 32'h0101_0101, 2'd0, 1'b0);
        check("R6 stays at max", acc_out, 64'hFFFF_FFFF_FFFF_FFFF);

        // R7 clear together with accumulate
        a = 32'h05_10_20_FF;
        b = 32'h10_05_20_00;
        issue(1'b1, 3'd3, a, b, 2'd0, 1'b1);
        check("R7 clear plus sad", acc_out, 64'h000B_000B_0000_00FF);

        // R7 clear alongside another operation
        issue(1'b1, 3'd0, 32'h0102_0304, 32'h1010_1010, 2'd0, 1'b1);
        check("R7 clear with add8 acc", acc_out, 64'd0);
        check("R2 add8 during clear", {32'd0, result}, 64'h0000_0000_1112_1314);

        // R7 clear while idle after loading
        issue(1'b1, 3'd3, 32'h0000_0000, 32'h0102_0304, 2'd0, 1'b0);
        check("R5 after clear", acc_out, 64'h0001_0002_0003_0004);
        issue(1'b0, 3'd0, 32'h0, 32'h0, 2'd0, 1'b1);
        check("R7 idle clear", acc_out, 64'd0);

        issue(1'b0, 3'd0, 32'h0, 32'h0, 2'd0, 1'b0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule